// File: doc/BRIEF.md
# Compare-Skip and Decimal-Adjust Execution Unit

This unit is one slice of an 8-bit accumulator processor. It runs a fixed four-phase instruction cycle: decode, read, execute, write. In each cycle it takes one 16-bit instruction word and executes one of two operations. Both operations work against an external 256 x 8 data file and an internal working register (W).

The first operation is an unsigned compare. When the addressed file byte is below W, the unit raises a skip output, and the instruction presented in the next cycle is executed as a no-operation. The second operation is a packed-BCD decimal adjust of a file byte. It corrects each nibble independently and updates the carry flag. The result always goes back to the file byte, and it can also go into W. Every other instruction word is a no-operation.

The data file stays outside the unit. The unit drives an address, a write strobe and write data, and it reads a combinational read-data input.

Top module: `cbu_unit`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets W to 0, carry to 0, digit-carry to 0 and skip_o to 0. It also sets the phase to 0 (decode), and the phase stays at 0 while rst is held.
- R2: phase_o steps 0,1,2,3,0,... one step per clock. The unit captures instr at the edge that ends phase 0. rf_addr equals bits [7:0] of the captured word. rf_we is asserted only in phase 3, and the file write lands on the edge that ends phase 3.
- R3: A word whose bits [15:8] are 0x30 is an unsigned compare. When file[f] < W, skip_o rises on the edge ending phase 3 and stays high for exactly the next four phases. W, carry and the file are left unchanged.
- R4: A compare with file[f] >= W, including equality, leaves skip_o low.
- R5: While skip_o is high, the instruction word captured in that cycle is ignored and executed as a no-operation. A compare or decimal-adjust presented then changes no file byte, no W, no carry and no skip.
- R6: A word whose bits [15:9] are 0010111 is a decimal adjust, with bit 8 = s. If the low nibble is above 9 or digit-carry is set, 6 is added to the low nibble modulo 16.
- R7: If the high nibble is above 9 or carry is set, 6 is added to the high nibble modulo 16, with no propagation from the low nibble. Carry becomes the carry out of that high-nibble addition, or 0 when no high correction is made. For example, 0xA5 with C=0 gives 0x05 with C=1, and 0xCE with C=0 gives 0x24 with C=1.
- R8: A decimal adjust with s=0 writes the result to file[f] and to W. With s=1 it writes file[f] only, and W is unchanged.
- R9: Any other instruction word writes nothing and changes no W, carry or skip.
- R10: Digit-carry is changed by neither operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 16 | Instruction word, sampled at the end of phase 0 |
| rf_rdata | input | 8 | Combinational read data of the data file at rf_addr |
| rf_addr | output | 8 | Data file address (operand field of the captured word) |
| rf_we | output | 1 | Data file write strobe, phase 3 only |
| rf_wdata | output | 8 | Data file write data |
| wreg_o | output | 8 | Working register W |
| carry_o | output | 1 | Carry flag |
| dcarry_o | output | 1 | Digit-carry flag |
| skip_o | output | 1 | Next instruction is forced to a no-operation |
| phase_o | output | 2 | Current phase, 0 = decode through 3 = write |

## Verification
The assertions assume that reset is held for at least two clocks, so that the first post-reset comparisons with past values see reset state. They also assume that rf_rdata is a pure function of rf_addr and stays stable from phase 1 onward, which lets the captured operand match the file contents.

The bench drives instr only at falling edges and changes it only at the start of phase 0. It updates its file model only through the unit's own write strobe, except for preloads made between instruction cycles, so both assumptions hold at all times.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
  localparam int DW       = 8;
  localparam int AW       = 8;
  localparam int IW       = DW + AW;
  localparam int NIB_W    = DW / 2;
  localparam int OPC_W    = IW - AW;
  localparam int BCD_MAX  = 9;
  localparam int BCD_FIX  = 6;
  localparam logic [OPC_W-1:0] OPC_CMPLT = 8'h30;
  localparam logic [OPC_W-2:0] OPC_DAW   = 7'b0010111;

  typedef logic [DW-1:0] data_t;
  typedef logic [AW-1:0] addr_t;
  typedef logic [IW-1:0] instr_t;

  typedef enum logic [1:0] {
    PH_DEC  = 2'd0,
    PH_READ = 2'd1,
    PH_EXEC = 2'd2,
    PH_WR   = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_CMPLT = 2'd1,
    OP_DAW   = 2'd2
  } op_e;

  typedef struct packed {
    logic  cout;
    data_t val;
  } daw_t;

  // Each nibble is corrected on its own; no carry crosses between them.
  function automatic daw_t daw_adjust(data_t v, logic c, logic dc);
    logic [NIB_W:0] lo;
    logic [NIB_W:0] hi;
    daw_t r;
    lo = {1'b0, v[NIB_W-1:0]};
    hi = {1'b0, v[DW-1:NIB_W]};
    if (lo > (NIB_W+1)'(BCD_MAX) || dc) lo = lo + (NIB_W+1)'(BCD_FIX);
    if (hi > (NIB_W+1)'(BCD_MAX) || c)  hi = hi + (NIB_W+1)'(BCD_FIX);
    r.val  = {hi[NIB_W-1:0], lo[NIB_W-1:0]};
    r.cout = hi[NIB_W];
    return r;
  endfunction

  function automatic op_e decode_op(instr_t w);
    if (w[IW-1:AW] == OPC_CMPLT)        return OP_CMPLT;
    else if (w[IW-1:AW+1] == OPC_DAW)   return OP_DAW;
    else                                return OP_NOP;
  endfunction
endpackage

// File: rtl/cbu_phase_seq.sv
module cbu_phase_seq
  import cbu_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  output phase_e phase
);
  localparam int PH_W = $bits(phase_e);
  logic [PH_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + PH_W'(1);
  end

  assign phase = phase_e'(cnt_q);
endmodule

// File: rtl/cbu_decode.sv
module cbu_decode
  import cbu_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_e phase,
  input  instr_t instr,
  input  logic   suppress,
  output addr_t  faddr,
  output op_e    op,
  output logic   file_only
);
  instr_t ir_q;

  // A word captured under skip is replaced by an all-zero no-operation.
  always_ff @(posedge clk) begin
    if (rst)                 ir_q <= '0;
    else if (phase == PH_DEC) ir_q <= suppress ? '0 : instr;
  end

  assign faddr     = ir_q[AW-1:0];
  assign op        = decode_op(ir_q);
  assign file_only = ir_q[AW];
endmodule

// File: rtl/cbu_exec.sv
module cbu_exec
  import cbu_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_e phase,
  input  op_e    op,
  input  logic   file_only,
  input  data_t  rf_rdata,
  output data_t  wreg,
  output logic   carry,
  output logic   dcarry,
  output data_t  result,
  output logic   cmp_less,
  output logic   daw_commit,
  output logic   wreg_load
);
  data_t opnd_q;
  data_t res_q;
  logic  res_c_q;
  logic  lt_q;
  data_t wreg_q;
  logic  carry_q;
  logic  dcarry_q;
  daw_t  adj;

  assign adj        = daw_adjust(opnd_q, carry_q, dcarry_q);
  assign daw_commit = (phase == PH_WR) && (op == OP_DAW);
  assign wreg_load  = daw_commit && !file_only;

  always_ff @(posedge clk) begin
    if (rst) begin
      opnd_q   <= '0;
      res_q    <= '0;
      res_c_q  <= 1'b0;
      lt_q     <= 1'b0;
      wreg_q   <= '0;
      carry_q  <= 1'b0;
      dcarry_q <= 1'b0;
    end else begin
      dcarry_q <= dcarry_q;
      unique case (phase)
        PH_READ: opnd_q <= rf_rdata;
        PH_EXEC: begin
          res_q   <= adj.val;
          res_c_q <= adj.cout;
          lt_q    <= (opnd_q < wreg_q);
        end
        PH_WR: begin
          if (daw_commit) carry_q <= res_c_q;
          if (wreg_load)  wreg_q  <= res_q;
        end
        default: ;
      endcase
    end
  end

  assign wreg     = wreg_q;
  assign carry    = carry_q;
  assign dcarry   = dcarry_q;
  assign result   = res_q;
  assign cmp_less = lt_q;
endmodule

// File: rtl/cbu_skip_ctrl.sv
module cbu_skip_ctrl
  import cbu_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_e phase,
  input  op_e    op,
  input  logic   cmp_less,
  output logic   skip_taken,
  output logic   skip
);
  logic skip_q;

  assign skip_taken = (phase == PH_WR) && (op == OP_CMPLT) && cmp_less;

  // Re-evaluated once per instruction cycle, so it lasts exactly one cycle.
  always_ff @(posedge clk) begin
    if (rst)                 skip_q <= 1'b0;
    else if (phase == PH_WR) skip_q <= skip_taken;
  end

  assign skip = skip_q;
endmodule

// File: rtl/cbu_unit.sv
module cbu_unit
  import cbu_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] instr,
  input  logic [DW-1:0] rf_rdata,
  output logic [AW-1:0] rf_addr,
  output logic          rf_we,
  output logic [DW-1:0] rf_wdata,
  output logic [DW-1:0] wreg_o,
  output logic          carry_o,
  output logic          dcarry_o,
  output logic          skip_o,
  output logic [1:0]    phase_o
);
  phase_e phase;
  op_e    op;
  addr_t  faddr;
  logic   file_only;
  logic   cmp_less;
  logic   daw_commit;
  logic   wreg_load;
  logic   skip_taken;
  logic   skip;
  data_t  result;

  cbu_phase_seq u_seq (.clk(clk), .rst(rst), .phase(phase));

  cbu_decode u_dec (
    .clk(clk), .rst(rst), .phase(phase), .instr(instr), .suppress(skip),
    .faddr(faddr), .op(op), .file_only(file_only)
  );

  cbu_exec u_exe (
    .clk(clk), .rst(rst), .phase(phase), .op(op), .file_only(file_only),
    .rf_rdata(rf_rdata), .wreg(wreg_o), .carry(carry_o), .dcarry(dcarry_o),
    .result(result), .cmp_less(cmp_less), .daw_commit(daw_commit),
    .wreg_load(wreg_load)
  );

  cbu_skip_ctrl u_skp (
    .clk(clk), .rst(rst), .phase(phase), .op(op), .cmp_less(cmp_less),
    .skip_taken(skip_taken), .skip(skip)
  );

  assign rf_addr  = faddr;
  assign rf_we    = daw_commit;
  assign rf_wdata = result;
  assign skip_o   = skip;
  assign phase_o  = phase;
endmodule

// File: rtl/cbu_checks.sv
module cbu_checks (
  input logic       clk,
  input logic       rst,
  input logic [1:0] phase,
  input logic       skip,
  input logic       skip_taken,
  input logic       rf_we,
  input logic       carry,
  input logic       dcarry,
  input logic [7:0] wreg,
  input logic       daw_commit,
  input logic       wreg_load
);
  p_phase_step_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> phase == $past(phase) + 2'd1);

  p_we_in_write_r2: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> phase == 2'd3);

  p_skip_at_boundary_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(skip) |-> $past(phase) == 2'd3);

  p_skip_rise_cause_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(skip) |-> $past(skip_taken));

  p_skip_single_r5: assert property (@(posedge clk) disable iff (rst)
    (skip && phase == 2'd3) |=> !skip);

  p_carry_only_daw_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(carry) |-> $past(daw_commit));

  p_wreg_only_load_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(wreg) |-> $past(wreg_load));

  p_dcarry_kept_r10: assert property (@(posedge clk) disable iff (rst)
    $past(daw_commit) |-> $stable(dcarry));
endmodule

bind cbu_unit cbu_checks chk_i (
  .clk(clk), .rst(rst), .phase(phase_o), .skip(skip_o), .skip_taken(skip_taken),
  .rf_we(rf_we), .carry(carry_o), .dcarry(dcarry_o), .wreg(wreg_o),
  .daw_commit(daw_commit), .wreg_load(wreg_load)
);

// File: tb/cbu_unit_tb_top.sv
`timescale 1ns/1ps
module cbu_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instr = 16'h0000;
  logic [7:0]  rf_rdata;
  logic [7:0]  rf_addr;
  logic        rf_we;
  logic [7:0]  rf_wdata;
  logic [7:0]  wreg_o;
  logic        carry_o;
  logic        dcarry_o;
  logic        skip_o;
  logic [1:0]  phase_o;

  logic [7:0] mem [256];
  int total = 0;
  int bad   = 0;
  int we_bad = 0;
  logic skip_all;
  logic [7:0] w_exp;

  always #2.5 clk = ~clk;

  cbu_unit dut_i (
    .clk(clk), .rst(rst), .instr(instr), .rf_rdata(rf_rdata),
    .rf_addr(rf_addr), .rf_we(rf_we), .rf_wdata(rf_wdata),
    .wreg_o(wreg_o), .carry_o(carry_o), .dcarry_o(dcarry_o),
    .skip_o(skip_o), .phase_o(phase_o)
  );

  assign rf_rdata = mem[rf_addr];
  always @(posedge clk) if (rf_we) mem[rf_addr] <= rf_wdata;

  always @(negedge clk) if (!rst && rf_we && phase_o != 2'd3) we_bad++;

  // addr, file value, s, expected result, expected carry; carry chains entry to entry
  localparam logic [25:0] VEC [10] = '{
    {8'h10, 8'hA5, 1'b1, 8'h05, 1'b1},
    {8'h11, 8'h05, 1'b0, 8'h65, 1'b0},
    {8'h12, 8'hCE, 1'b1, 8'h24, 1'b1},
    {8'h13, 8'h12, 1'b0, 8'h72, 1'b0},
    {8'h14, 8'h99, 1'b1, 8'h99, 1'b0},
    {8'h15, 8'h9A, 1'b0, 8'h90, 1'b0},
    {8'h16, 8'hFF, 1'b1, 8'h55, 1'b1},
    {8'h17, 8'h00, 1'b0, 8'h60, 1'b0},
    {8'h18, 8'h3B, 1'b1, 8'h31, 1'b0},
    {8'h19, 8'hF0, 1'b0, 8'h50, 1'b1}
  };

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Called at a falling edge in phase 0; returns at the falling edge in phase 0 of the next cycle.
  task automatic exec(input logic [15:0] iw);
    while (phase_o != 2'd0) @(negedge clk);
    instr = iw;
    skip_all = skip_o;
    for (int p = 1; p < 4; p++) begin
      @(negedge clk);
      skip_all = skip_all & skip_o;
    end
    @(negedge clk);
    instr = 16'h0000;
  endtask

  function automatic logic [15:0] daw_w(input logic s, input logic [7:0] a);
    return {7'b0010111, s, a};
  endfunction

  function automatic logic [15:0] cmp_w(input logic [7:0] a);
    return {8'h30, a};
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i);
    repeat (4) @(negedge clk);
    chk("R1", "wreg after reset", wreg_o, 8'h00);
    chk("R1", "carry after reset", {7'b0, carry_o}, 8'h00);
    chk("R1", "dcarry after reset", {7'b0, dcarry_o}, 8'h00);
    chk("R1", "skip after reset", {7'b0, skip_o}, 8'h00);
    chk("R1", "phase held in reset", {6'b0, phase_o}, 8'h00);
    rst = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      chk("R2", "phase step", {6'b0, phase_o}, 8'(k % 4));
    end

    // R6 R7 R8 R10: table of decimal-adjust vectors
    w_exp = 8'h00;
    foreach (VEC[i]) begin
      logic [7:0] a, f, r;
      logic s, c;
      {a, f, s, r, c} = VEC[i];
      mem[a] = f;
      exec(daw_w(s, a));
      if (s == 1'b0) w_exp = r;
      chk("R6/R7", "adjusted file byte", mem[a], r);
      chk("R7", "carry after adjust", {7'b0, carry_o}, {7'b0, c});
      chk("R8", "wreg per destination", wreg_o, w_exp);
      chk("R10", "dcarry untouched", {7'b0, dcarry_o}, 8'h00);
      chk("R3", "no skip from adjust", {7'b0, skip_o}, 8'h00);
    end

    // load W = 0xA0: 0x40 with C=1 adds 6 to the high nibble, no carry out
    mem[8'h80] = 8'h40;
    exec(daw_w(1'b0, 8'h80));
    chk("R8", "wreg loaded", wreg_o, 8'hA0);
    chk("R7", "carry cleared without overflow", {7'b0, carry_o}, 8'h00);

    // R3: 0x9F < 0xA0 gives a skip
    mem[8'h81] = 8'h9F;
    exec(cmp_w(8'h81));
    chk("R3", "skip after less-than", {7'b0, skip_o}, 8'h01);
    chk("R3", "wreg kept by compare", wreg_o, 8'hA0);
    chk("R3", "carry kept by compare", {7'b0, carry_o}, 8'h00);
    chk("R3", "file kept by compare", mem[8'h81], 8'h9F);

    // R5: the adjust in the shadow is suppressed
    mem[8'h82] = 8'hAA;
    exec(daw_w(1'b0, 8'h82));
    chk("R3", "skip held whole cycle", {7'b0, skip_all}, 8'h01);
    chk("R3", "skip drops after one cycle", {7'b0, skip_o}, 8'h00);
    chk("R5", "suppressed file byte", mem[8'h82], 8'hAA);
    chk("R5", "suppressed wreg", wreg_o, 8'hA0);
    chk("R5", "suppressed carry", {7'b0, carry_o}, 8'h00);

    // R4: equality and greater do not skip
    mem[8'h83] = 8'hA0;
    exec(cmp_w(8'h83));
    chk("R4", "no skip when equal", {7'b0, skip_o}, 8'h00);
    mem[8'h84] = 8'hFF;
    exec(cmp_w(8'h84));
    chk("R4", "no skip when greater", {7'b0, skip_o}, 8'h00);

    // R3: unsigned, 0x7F < 0xA0
    mem[8'h85] = 8'h7F;
    exec(cmp_w(8'h85));
    chk("R3", "unsigned less-than skips", {7'b0, skip_o}, 8'h01);
    // R5: a compare in the shadow that would skip is ignored
    mem[8'h86] = 8'h00;
    exec(cmp_w(8'h86));
    chk("R5", "shadowed compare has no effect", {7'b0, skip_o}, 8'h00);

    // R9: near-miss opcodes
    mem[8'h55] = 8'h01;
    exec(16'h3155);
    chk("R9", "0x31 no skip", {7'b0, skip_o}, 8'h00);
    exec(16'h2C55);
    chk("R9", "0x2C file unchanged", mem[8'h55], 8'h01);
    chk("R9", "0x2C wreg unchanged", wreg_o, 8'hA0);
    chk("R9", "0x2C carry unchanged", {7'b0, carry_o}, 8'h00);
    exec(16'h0055);
    chk("R9", "zero word file unchanged", mem[8'h55], 8'h01);

    chk("R2", "write strobe outside phase 3", 8'(we_bad), 8'h00);

    // R1: reset mid-run
    mem[8'h90] = 8'hF9;
    exec(daw_w(1'b0, 8'h90));
    chk("R7", "high overflow sets carry", {7'b0, carry_o}, 8'h01);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "wreg after late reset", wreg_o, 8'h00);
    chk("R1", "carry after late reset", {7'b0, carry_o}, 8'h00);
    chk("R1", "phase after late reset", {6'b0, phase_o}, 8'h00);
    rst = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule